// File: doc/BRIEF.md
# Looping Sideband Command Sequencer

This block runs a short list of preloaded commands, one after another and round and round, on a narrow control bus that sits beside a wide peripheral data bus. Software fills a command table of up to twelve words through a register-write port. It sets an active-entry count and then sets an enable bit. From then on, the sequencer needs no further software help. It runs a fixed four-clock bus cycle for each active entry, and after the last active entry it returns to entry 0.

A command can do one of four things. It can sample a device's FIFO status byte, send a flow-control byte to a MAC, write a byte to a device, or read a byte from a device. Sampled status bytes are kept in one register per device, and each register has a valid flag. The last generic read result is kept in a separate register. The host reads both through a combinational lookup port. The side bus uses the same clock as the main bus, but its cycles are entirely its own.

Top module: `sbseq_top`

## Requirements
- R1: After reset the enable bit is clear, `sb_oe` is 0, `sb_ctl` and `sb_dout` are all zeros, every status valid flag is 0, and `rd_last` is 0.
- R2: A write to addresses 0..11 stores the table entry, and a write to address 12 stores the active count, but only while enable is clear. While enable is set, both kinds of write are ignored. Address 13 writes the enable bit from `wr_data[0]` at all times. A table word holds the opcode in bits [12:11], the device select in [10:8] and the data field in [7:0].
- R3: A count write is clamped: a value of 0 becomes 1, a value above 12 becomes 12, and any other value is kept.
- R4: In the cycle after enable goes from 0 to 1, the address phase of entry 0 is on the bus.
- R5: Each command takes exactly four clocks:
  - address: `sb_oe`=1, `sb_ctl`=5'b10001, `sb_dout`={opcode, device, 3'b000};
  - turnaround: `sb_ctl`=5'b10000, `sb_oe`=0, `sb_dout`=0;
  - data;
  - idle: all outputs zero.
- R6: In the data phase of a write-type command (opcode 01 flow control, opcode 10 generic write), `sb_oe`=1 and `sb_dout` is the data field. `sb_ctl` is 5'b11100 for flow control and 5'b10100 for a generic write.
- R7: In the data phase of a read-type command (opcode 00 status sample, opcode 11 generic read), `sb_oe`=0, `sb_dout`=0 and `sb_ctl`=5'b10010. For a status sample, `sb_din` at the end of that phase is stored for the selected device, and that device's valid flag is set. `rd_status` and `rd_valid` show this for `rd_dev` from the next cycle.
- R8: For a generic read, `sb_din` at the end of the data phase appears on `rd_last` from the next cycle. The status registers are unchanged.
- R9: After the idle phase of entry count-1, the next command is entry 0. Otherwise the next command is the following entry.
- R10: Clearing enable makes all bus outputs zero from the next cycle. A later enable restarts at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the main bus |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0..11 table, 12 count, 13 enable |
| wr_data | input | 13 | Write data |
| sb_din | input | 8 | Side bus data in |
| sb_dout | output | 8 | Side bus data out |
| sb_oe | output | 1 | Side bus output enable |
| sb_ctl | output | 5 | Side bus control: [0] address strobe, [1] read strobe, [2] write strobe, [3] flow-control mark, [4] frame |
| rd_dev | input | 3 | Device whose status is shown |
| rd_status | output | 8 | Stored status byte of `rd_dev` |
| rd_valid | output | 1 | Status valid flag of `rd_dev` |
| rd_last | output | 8 | Last generic read byte |

## Verification
The bench builds the block with its default parameters: twelve table slots, eight devices and an 8-bit data field. With these values, every count from the clamped lower bound of 1 up to the full table is reachable, including the wrap from slot 11 back to slot 0. All eight status registers can be addressed. A behavioural model tracks enable, slot, phase, the stored table and the captured bytes. The bench compares every bus output and read port against this model on every clock while the count, the enable and the ignored writes change.

// File: rtl/sbseq_pkg.sv
package sbseq_pkg;

  typedef enum logic [1:0] {
    OP_STAT  = 2'b00,
    OP_FLOW  = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } sb_op_e;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_TURN = 2'd1,
    PH_DATA = 2'd2,
    PH_IDLE = 2'd3
  } sb_phase_e;

  localparam int CTL_ALE = 0;
  localparam int CTL_RD  = 1;
  localparam int CTL_WR  = 2;
  localparam int CTL_FC  = 3;
  localparam int CTL_FRM = 4;
  localparam int CTL_W   = 5;

  function automatic logic op_drives(sb_op_e op);
    return (op == OP_FLOW) || (op == OP_WRITE);
  endfunction

  function automatic int unsigned clamp_count(int unsigned req, int unsigned lim);
    if (req == 0) return 1;
    if (req > lim) return lim;
    return req;
  endfunction

  function automatic int unsigned next_slot(int unsigned cur, int unsigned cnt);
    return (cur + 1 >= cnt) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/sbseq_cmd_store.sv
module sbseq_cmd_store import sbseq_pkg::*; #(
  parameter int N_SLOTS = 12,
  parameter int ADDR_W  = 4,
  parameter int WORD_W  = 13,
  parameter int SLOT_W  = 4,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] slot,
  output logic [WORD_W-1:0] cmd_word,
  output logic [CNT_W-1:0]  count,
  output logic              run,
  output logic              tab_we,
  output logic              cnt_we
);

  localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(N_SLOTS);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(N_SLOTS + 1);

  logic [WORD_W-1:0] tab [N_SLOTS];

  assign tab_we = wr_en && !run && (wr_addr < CNT_ADDR);
  assign cnt_we = wr_en && !run && (wr_addr == CNT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) tab[i] <= '0;
    end else if (tab_we) begin
      tab[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= CNT_W'(N_SLOTS);
      run   <= 1'b0;
    end else begin
      if (cnt_we) count <= CNT_W'(clamp_count(32'(wr_data), N_SLOTS));
      if (wr_en && wr_addr == CTL_ADDR) run <= wr_data[0];
    end
  end

  assign cmd_word = tab[slot];

endmodule

// File: rtl/sbseq_engine.sv
module sbseq_engine import sbseq_pkg::*; #(
  parameter int SLOT_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CNT_W-1:0]  count,
  input  sb_op_e            op,
  output logic [SLOT_W-1:0] slot,
  output sb_phase_e         phase,
  output logic              cap_stb,
  output logic              cmd_end
);

  assign cmd_end = run && (phase == PH_IDLE);
  assign cap_stb = run && (phase == PH_DATA) && !op_drives(op);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      slot  <= '0;
      phase <= PH_ADDR;
    end else begin
      phase <= sb_phase_e'(2'(phase + 2'd1));
      if (cmd_end) slot <= SLOT_W'(next_slot(32'(slot), 32'(count)));
    end
  end

endmodule

// File: rtl/sbseq_bus.sv
module sbseq_bus import sbseq_pkg::*; #(
  parameter int DEV_W = 3,
  parameter int DAT_W = 8
) (
  input  logic             run,
  input  sb_phase_e        phase,
  input  sb_op_e           op,
  input  logic [DEV_W-1:0] dev,
  input  logic [DAT_W-1:0] fld,
  output logic [DAT_W-1:0] sb_dout,
  output logic             sb_oe,
  output logic [CTL_W-1:0] sb_ctl
);

  localparam int PAD = DAT_W - 2 - DEV_W;

  always_comb begin
    sb_dout = '0;
    sb_oe   = 1'b0;
    sb_ctl  = '0;
    if (run) begin
      unique case (phase)
        PH_ADDR: begin
          sb_oe           = 1'b1;
          sb_dout         = {op, dev, {PAD{1'b0}}};
          sb_ctl[CTL_ALE] = 1'b1;
          sb_ctl[CTL_FRM] = 1'b1;
        end
        PH_TURN: sb_ctl[CTL_FRM] = 1'b1;
        PH_DATA: begin
          sb_ctl[CTL_FRM] = 1'b1;
          if (op_drives(op)) begin
            sb_oe          = 1'b1;
            sb_dout        = fld;
            sb_ctl[CTL_WR] = 1'b1;
            sb_ctl[CTL_FC] = (op == OP_FLOW);
          end else begin
            sb_ctl[CTL_RD] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sbseq_status.sv
module sbseq_status import sbseq_pkg::*; #(
  parameter int DEV_W = 3,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_stb,
  input  sb_op_e           op,
  input  logic [DEV_W-1:0] dev,
  input  logic [DAT_W-1:0] sb_din,
  input  logic [DEV_W-1:0] rd_dev,
  output logic [DAT_W-1:0] rd_status,
  output logic             rd_valid,
  output logic [DAT_W-1:0] rd_last
);

  localparam int N_DEV = 1 << DEV_W;

  logic [DAT_W-1:0] stat [N_DEV];
  logic [N_DEV-1:0] vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < N_DEV; d++) stat[d] <= '0;
      vld     <= '0;
      rd_last <= '0;
    end else if (cap_stb) begin
      if (op == OP_STAT) begin
        stat[dev] <= sb_din;
        vld[dev]  <= 1'b1;
      end else begin
        rd_last <= sb_din;
      end
    end
  end

  assign rd_status = stat[rd_dev];
  assign rd_valid  = vld[rd_dev];

endmodule

// File: rtl/sbseq_top.sv
module sbseq_top import sbseq_pkg::*; #(
  parameter int N_SLOTS = 12,
  parameter int DEV_W   = 3,
  parameter int DAT_W   = 8,
  localparam int ADDR_W = $clog2(N_SLOTS + 2),
  localparam int WORD_W = 2 + DEV_W + DAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [DAT_W-1:0]  sb_din,
  output logic [DAT_W-1:0]  sb_dout,
  output logic              sb_oe,
  output logic [4:0]        sb_ctl,
  input  logic [DEV_W-1:0]  rd_dev,
  output logic [DAT_W-1:0]  rd_status,
  output logic              rd_valid,
  output logic [DAT_W-1:0]  rd_last
);

  localparam int SLOT_W = $clog2(N_SLOTS);
  localparam int CNT_W  = $clog2(N_SLOTS + 1);

  logic [WORD_W-1:0] cmd_word;
  logic [CNT_W-1:0]  count;
  logic              run;
  logic              tab_we;
  logic              cnt_we;
  logic [SLOT_W-1:0] slot;
  sb_phase_e         phase;
  logic              cap_stb;
  logic              cmd_end;
  sb_op_e            op;
  logic [DEV_W-1:0]  dev;
  logic [DAT_W-1:0]  fld;

  assign op  = sb_op_e'(cmd_word[WORD_W-1 -: 2]);
  assign dev = cmd_word[DAT_W +: DEV_W];
  assign fld = cmd_word[DAT_W-1:0];

  sbseq_cmd_store #(
    .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slot(slot), .cmd_word(cmd_word),
    .count(count), .run(run), .tab_we(tab_we), .cnt_we(cnt_we)
  );

  sbseq_engine #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) i_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .count(count), .op(op),
    .slot(slot), .phase(phase), .cap_stb(cap_stb), .cmd_end(cmd_end)
  );

  sbseq_bus #(.DEV_W(DEV_W), .DAT_W(DAT_W)) i_bus (
    .run(run), .phase(phase), .op(op), .dev(dev), .fld(fld),
    .sb_dout(sb_dout), .sb_oe(sb_oe), .sb_ctl(sb_ctl)
  );

  sbseq_status #(.DEV_W(DEV_W), .DAT_W(DAT_W)) i_status (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .op(op), .dev(dev),
    .sb_din(sb_din), .rd_dev(rd_dev), .rd_status(rd_status),
    .rd_valid(rd_valid), .rd_last(rd_last)
  );

endmodule

// File: rtl/sbseq_chk.sv
module sbseq_chk #(
  parameter int N_SLOTS = 12,
  parameter int SLOT_W  = 4,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [CNT_W-1:0]  count,
  input logic [SLOT_W-1:0] slot,
  input logic              cap_stb,
  input logic              cmd_end,
  input logic              tab_we,
  input logic              sb_oe,
  input logic [4:0]        sb_ctl
);

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sb_ctl == 5'b0 && !sb_oe));  // R10
  AST_START_AT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (sb_ctl == 5'b10001 && slot == '0));  // R4
  AST_ADDR_THEN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sb_ctl[0]) |=> (!run || sb_ctl == 5'b10000));  // R5
  AST_TURN_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sb_ctl == 5'b10000) |=> (!run || sb_ctl[1] || sb_ctl[2]));  // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sb_ctl[2:0]));  // R5
  AST_FC_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ctl[3] |-> (sb_ctl[2] && sb_oe));  // R6
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ctl[1] |-> !sb_oe);  // R7
  AST_CAPTURE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> sb_ctl[1]);  // R7
  AST_END_THEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> (!run || sb_ctl == 5'b10001));  // R9
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot) < 32'(count));  // R9
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(count) >= 1 && 32'(count) <= N_SLOTS));  // R3
  AST_NO_TABLE_WRITE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !tab_we);  // R2
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(count));  // R2

endmodule

bind sbseq_top sbseq_chk #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .count(count), .slot(slot),
  .cap_stb(cap_stb), .cmd_end(cmd_end), .tab_we(tab_we),
  .sb_oe(sb_oe), .sb_ctl(sb_ctl)
);

// File: tb/test_sbseq_top.sv
`timescale 1ns/1ps
module test_sbseq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [7:0]  sb_din = 8'h5a;
  logic [7:0]  sb_dout;
  logic        sb_oe;
  logic [4:0]  sb_ctl;
  logic [2:0]  rd_dev = '0;
  logic [7:0]  rd_status;
  logic        rd_valid;
  logic [7:0]  rd_last;

  int checks = 0;
  int errors = 0;
  string scen = "R1";

  sbseq_top i_sbseq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sb_din(sb_din), .sb_dout(sb_dout), .sb_oe(sb_oe),
    .sb_ctl(sb_ctl), .rd_dev(rd_dev), .rd_status(rd_status),
    .rd_valid(rd_valid), .rd_last(rd_last)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_en, m_ptr, m_ph, m_cnt, m_last;
  int m_tab[12];
  int m_stat[8];
  int m_val[8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ptr = 0; m_ph = 0; m_cnt = 12; m_last = 0;
      foreach (m_tab[i]) m_tab[i] = 0;
      foreach (m_stat[i]) begin m_stat[i] = 0; m_val[i] = 0; end
    end else begin
      int op, dev, new_en;
      op = m_tab[m_ptr] >> 11;
      dev = (m_tab[m_ptr] >> 8) & 7;
      new_en = m_en;
      if (wr_en) begin
        if (wr_addr < 12 && m_en == 0) m_tab[wr_addr] = int'(wr_data);
        if (wr_addr == 12 && m_en == 0)
          m_cnt = (wr_data == 0) ? 1 : (wr_data > 12) ? 12 : int'(wr_data);
        if (wr_addr == 13) new_en = int'(wr_data[0]);
      end
      if (m_en == 0) begin
        m_ptr = 0; m_ph = 0;
      end else begin
        if (m_ph == 2 && op == 0) begin m_stat[dev] = int'(sb_din); m_val[dev] = 1; end
        if (m_ph == 2 && op == 3) m_last = int'(sb_din);
        if (m_ph == 3) m_ptr = (m_ptr + 1 == m_cnt) ? 0 : m_ptr + 1;
        m_ph = (m_ph + 1) % 4;
      end
      m_en = new_en;
    end
  end

  // stimulus on the side bus and the read port, away from the edge
  logic [7:0] lfsr = 8'h5a;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    sb_din = lfsr;
    rd_dev = rd_dev + 3'd1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (scenario %s) actual %0h expected %0h at %0t", tag, scen, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int e_dout, e_oe, e_ctl, op, dev, fld;
      string tag;
      op = m_tab[m_ptr] >> 11;
      dev = (m_tab[m_ptr] >> 8) & 7;
      fld = m_tab[m_ptr] & 255;
      e_dout = 0; e_oe = 0; e_ctl = 0; tag = "R10";
      if (m_en != 0) begin
        case (m_ph)
          0: begin e_oe = 1; e_dout = (op << 6) | (dev << 3); e_ctl = 5'b10001; tag = "R9"; end
          1: begin e_ctl = 5'b10000; tag = "R5"; end
          2: if (op == 1 || op == 2) begin
               e_oe = 1; e_dout = fld; e_ctl = (op == 1) ? 5'b11100 : 5'b10100; tag = "R6";
             end else begin
               e_ctl = 5'b10010; tag = "R7";
             end
          default: tag = "R5";
        endcase
      end
      check(tag, int'(sb_dout), e_dout);
      check(tag, int'(sb_oe), e_oe);
      check(tag, int'(sb_ctl), e_ctl);
      check("R7", int'(rd_status), m_stat[rd_dev]);
      check("R7", int'(rd_valid), m_val[rd_dev]);
      check("R8", int'(rd_last), m_last);
    end
  end

  task automatic cfg(input int a, input int d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 13'(d);
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int word(input int op, input int dev, input int fld);
    return (op << 11) | (dev << 8) | fld;
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(sb_ctl), 0);
    check("R1", int'(sb_oe), 0);
    check("R1", int'(sb_dout), 0);
    check("R1", int'(rd_valid), 0);
    check("R1", int'(rd_last), 0);

    scen = "R9";
    for (int i = 0; i < 12; i++)
      cfg(i, word(i % 4, i % 8, 8'h10 + i * 7));
    cfg(12, 5);
    scen = "R4";
    cfg(13, 1);
    @(negedge clk);
    check("R4", int'(sb_ctl), 5'b10001);
    check("R4", int'(sb_dout), (0 << 6) | (0 << 3));
    scen = "R9";
    idle(60);

    scen = "R10";
    cfg(13, 0);
    @(negedge clk);
    check("R10", int'(sb_ctl), 0);
    scen = "R3";
    cfg(12, 0);
    cfg(13, 1);
    idle(20);
    cfg(13, 0);
    cfg(12, 15);
    cfg(13, 1);
    idle(120);

    scen = "R2";
    cfg(0, word(1, 5, 8'hee));
    cfg(12, 3);
    idle(60);

    scen = "R10";
    idle(2);
    cfg(13, 0);
    idle(3);
    cfg(13, 1);
    @(negedge clk);
    check("R10", int'(sb_ctl), 5'b10001);
    idle(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule